// File: doc/BRIEF.md
# Twin-Predicated Vector Element Sequencer

This block walks the element loop of one predicated vector operation. A start pulse captures a vector length, the starting source and destination steps, and the predicate settings. From then on the block issues at most one source/destination element pair per clock. The source side and the destination side each follow their own mask and move forward on their own. That independence gives compress (sparse source, dense destination), expand (dense source, sparse destination) and arbitrary remapping of one element onto another. Zeroing turns masked-off destination elements into zero writes. The live step counters are visible at the ports, so the loop can be stopped, saved and later resumed from any pair of step values.

The surrounding datapath reads source element `src_idx_o` and writes destination element `dst_idx_o` on every cycle in which `issue_o` is high. When `wr_zero_o` is also high, it writes zero instead of the result. A one-cycle `done_o` marks the end of the loop.

Top module: `pred_elem_seq`

## Requirements
- R1: While reset is held low, `issue_o`, `done_o`, `wr_zero_o`, both index outputs and both step outputs are zero.
- R2: Mask bit i governs element i. A source element whose effective mask bit is 0 produces no pair. The source step moves on to the next set bit at or above the current step.
- R3: The destination side skips clear mask bits in the same way, independently of the source side. Issued pairs may therefore map source element i to destination element j with i ≠ j. Within one loop, destination indices strictly increase.
- R4: `src_inv_i` and `dst_inv_i` each complement their own mask before use. For example, 0b101 inverted with a vector length of 3 selects only element 1.
- R5: The loop ends at the first cycle in which either side has no set bit left below the vector length. Later destination elements get no pair. Mask bits at or above the vector length are ignored. Element indices up to 63 and step values up to 64 are supported.
- R6: With `zero_i` set, the destination does not skip. A destination element with a clear mask bit is issued with `wr_zero_o`=1, and the source element paired with it is still consumed.
- R7: A vector length of 0 gives no pair at all, followed by `done_o`.
- R8: The source and destination steps load from `src_step_i` and `dst_step_i`, and the search starts there. For example, a source mask of 0101 from step 1 first uses element 2, and an inverted destination mask of 0101 from step 2 first writes element 3.
- R9: With `dst_scalar_i` set, the loop ends after its first pair. With `src_scalar_i` set, every pair reports source index 0 while the source step still walks the mask.
- R10: With `single_i` set, one mask, inverted by `src_inv_i`, governs both sides, and `dst_mask_i`/`dst_inv_i` are ignored. The mask is `cr_eq_i` (one equality bit per element) when `cr_sel_i` is 1, and `src_mask_i` otherwise.
- R11: At most one pair is issued per cycle. The first pair can appear in the cycle after the start edge. In each issue cycle, the step outputs already hold the issued index plus one.
- R12: `done_o` lasts one cycle, is never high together with `issue_o`, and shows both steps at zero. All inputs are latched at start. A start while the loop runs is ignored, and a start during the `done_o` cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a loop (accepted when idle) |
| vl_i | input | 7 | Vector length |
| src_step_i | input | 7 | Initial source step |
| dst_step_i | input | 7 | Initial destination step |
| src_mask_i | input | 64 | Integer source (or shared) mask |
| dst_mask_i | input | 64 | Integer destination mask |
| cr_eq_i | input | 64 | Per-element condition equality bits |
| src_inv_i | input | 1 | Invert source / shared mask |
| dst_inv_i | input | 1 | Invert destination mask |
| single_i | input | 1 | One mask for both sides |
| cr_sel_i | input | 1 | Shared mask taken from `cr_eq_i` |
| zero_i | input | 1 | Destination zeroing |
| src_scalar_i | input | 1 | Source operand is scalar |
| dst_scalar_i | input | 1 | Destination operand is scalar |
| issue_o | output | 1 | Element pair valid |
| src_idx_o | output | 6 | Source element index |
| dst_idx_o | output | 6 | Destination element index |
| wr_zero_o | output | 1 | Write zero to destination element |
| src_step_o | output | 7 | Live source step |
| dst_step_o | output | 7 | Live destination step |
| done_o | output | 1 | Loop finished (one cycle) |

## Verification
Two events can fall in the same cycle: the end of one loop and the request for the next. The start pulse for each new vector is driven during the exact cycle in which the previous loop shows `done_o`. The bench judges that the new length, masks and steps were taken, by checking the first pair and the step values of the new loop. A second start is also driven in the middle of each multi-pair loop, with every input scrambled at the same time. That start must not disturb the pairs already being issued, nor the step values that track them.

// File: rtl/tps_pkg.sv
package tps_pkg;

   // Implementation choice for the next-set-bit search.
   typedef enum logic [0:0] {
      FIND_LINEAR  = 1'b0,
      FIND_ISOLATE = 1'b1
   } find_impl_e;

   // Per-loop options latched at start.
   typedef struct packed {
      logic zero;
      logic src_scalar;
      logic dst_scalar;
   } run_flags_t;

endpackage

// File: rtl/tps_mask_prep.sv
module tps_mask_prep #(
   parameter int MASK_W = 64,
   parameter int VL_W   = 7
) (
   input  logic [VL_W-1:0]   vl_i,
   input  logic [MASK_W-1:0] src_mask_i,
   input  logic [MASK_W-1:0] dst_mask_i,
   input  logic [MASK_W-1:0] cr_eq_i,
   input  logic              src_inv_i,
   input  logic              dst_inv_i,
   input  logic              single_i,
   input  logic              cr_sel_i,
   output logic [MASK_W-1:0] s_eff_o,
   output logic [MASK_W-1:0] d_eff_o
);

   logic [MASK_W-1:0] in_range;
   logic [MASK_W-1:0] s_sel;
   logic [MASK_W-1:0] s_pol;
   logic [MASK_W-1:0] d_pol;

   // Elements at or above the vector length never take part.
   for (genvar i = 0; i < MASK_W; i++) begin : g_range
      assign in_range[i] = (VL_W'(i) < vl_i);
   end

   assign s_sel = (single_i && cr_sel_i) ? cr_eq_i : src_mask_i;
   assign s_pol = s_sel ^ {MASK_W{src_inv_i}};
   assign d_pol = single_i ? s_pol : (dst_mask_i ^ {MASK_W{dst_inv_i}});

   assign s_eff_o = s_pol & in_range;
   assign d_eff_o = d_pol & in_range;

endmodule

// File: rtl/tps_next_set.sv
module tps_next_set #(
   parameter int                  MASK_W = 64,
   parameter int                  VL_W   = 7,
   parameter tps_pkg::find_impl_e IMPL   = tps_pkg::FIND_LINEAR,
   localparam int                 IDX_W  = $clog2(MASK_W)
) (
   input  logic [MASK_W-1:0] mask_i,
   input  logic [VL_W-1:0]   from_i,
   output logic              found_o,
   output logic [IDX_W-1:0]  idx_o
);

   logic [MASK_W-1:0] at_or_above;
   logic [MASK_W-1:0] cand;

   for (genvar i = 0; i < MASK_W; i++) begin : g_thermo
      assign at_or_above[i] = (VL_W'(i) >= from_i);
   end

   assign cand    = mask_i & at_or_above;
   assign found_o = |cand;

   if (IMPL == tps_pkg::FIND_LINEAR) begin : g_linear
      // Priority scan from the top so the lowest set bit wins last.
      always_comb begin
         idx_o = '0;
         for (int i = MASK_W - 1; i >= 0; i--) begin
            if (cand[i]) idx_o = IDX_W'(i);
         end
      end
   end else begin : g_isolate
      // Isolate the lowest set bit, then encode the one-hot result.
      logic [MASK_W-1:0] lowest;
      assign lowest = cand & (~cand + MASK_W'(1));
      always_comb begin
         idx_o = '0;
         for (int i = 0; i < MASK_W; i++) begin
            if (lowest[i]) idx_o = idx_o | IDX_W'(i);
         end
      end
   end

endmodule

// File: rtl/tps_step_ctrl.sv
module tps_step_ctrl #(
   parameter int  MASK_W = 64,
   parameter int  VL_W   = 7,
   localparam int IDX_W  = $clog2(MASK_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [VL_W-1:0]   vl_i,
   input  logic [VL_W-1:0]   src_step_i,
   input  logic [VL_W-1:0]   dst_step_i,
   input  logic [MASK_W-1:0] s_eff_i,
   input  logic [MASK_W-1:0] d_eff_i,
   input  logic              zero_i,
   input  logic              src_scalar_i,
   input  logic              dst_scalar_i,
   input  logic              s_found_i,
   input  logic [IDX_W-1:0]  s_idx_i,
   input  logic              d_found_i,
   input  logic [IDX_W-1:0]  d_idx_i,
   output logic [MASK_W-1:0] smask_o,
   output logic [MASK_W-1:0] dmask_o,
   output logic [VL_W-1:0]   src_step_o,
   output logic [VL_W-1:0]   dst_step_o,
   output logic              issue_o,
   output logic [IDX_W-1:0]  src_idx_o,
   output logic [IDX_W-1:0]  dst_idx_o,
   output logic              wr_zero_o,
   output logic              done_o
);

   import tps_pkg::*;

   logic              busy_q;
   logic              stop_q;
   logic [VL_W-1:0]   vl_q;
   run_flags_t        flags_q;
   logic [MASK_W-1:0] smask_q;
   logic [MASK_W-1:0] dmask_q;
   logic [VL_W-1:0]   sstep_q;
   logic [VL_W-1:0]   dstep_q;

   logic              dz_ok;
   logic              d_ok;
   logic [IDX_W-1:0]  d_at;
   logic              d_zero;
   logic              advance;

   // Zeroing: destination stays on its current step instead of searching.
   assign dz_ok   = (dstep_q < vl_q);
   assign d_ok    = flags_q.zero ? dz_ok : d_found_i;
   assign d_at    = flags_q.zero ? dstep_q[IDX_W-1:0] : d_idx_i;
   assign d_zero  = flags_q.zero & ~dmask_q[d_at];
   assign advance = busy_q & ~stop_q & s_found_i & d_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q    <= 1'b0;
         stop_q    <= 1'b0;
         vl_q      <= '0;
         flags_q   <= '0;
         smask_q   <= '0;
         dmask_q   <= '0;
         sstep_q   <= '0;
         dstep_q   <= '0;
         issue_o   <= 1'b0;
         src_idx_o <= '0;
         dst_idx_o <= '0;
         wr_zero_o <= 1'b0;
         done_o    <= 1'b0;
      end else begin
         issue_o   <= 1'b0;
         wr_zero_o <= 1'b0;
         done_o    <= 1'b0;
         if (!busy_q) begin
            if (start_i) begin
               busy_q             <= 1'b1;
               stop_q             <= 1'b0;
               vl_q               <= vl_i;
               flags_q.zero       <= zero_i;
               flags_q.src_scalar <= src_scalar_i;
               flags_q.dst_scalar <= dst_scalar_i;
               smask_q            <= s_eff_i;
               dmask_q            <= d_eff_i;
               sstep_q            <= src_step_i;
               dstep_q            <= dst_step_i;
            end
         end else if (advance) begin
            issue_o   <= 1'b1;
            src_idx_o <= flags_q.src_scalar ? '0 : s_idx_i;
            dst_idx_o <= d_at;
            wr_zero_o <= d_zero;
            sstep_q   <= VL_W'(s_idx_i) + VL_W'(1);
            dstep_q   <= VL_W'(d_at) + VL_W'(1);
            stop_q    <= flags_q.dst_scalar;
         end else begin
            busy_q  <= 1'b0;
            stop_q  <= 1'b0;
            done_o  <= 1'b1;
            sstep_q <= '0;
            dstep_q <= '0;
         end
      end
   end

   assign smask_o    = smask_q;
   assign dmask_o    = dmask_q;
   assign src_step_o = sstep_q;
   assign dst_step_o = dstep_q;

endmodule

// File: rtl/pred_elem_seq.sv
module pred_elem_seq #(
   parameter int                  MASK_W    = 64,
   parameter int                  VL_W      = 7,
   parameter tps_pkg::find_impl_e FIND_IMPL = tps_pkg::FIND_LINEAR,
   localparam int                 IDX_W     = $clog2(MASK_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [VL_W-1:0]   vl_i,
   input  logic [VL_W-1:0]   src_step_i,
   input  logic [VL_W-1:0]   dst_step_i,
   input  logic [MASK_W-1:0] src_mask_i,
   input  logic [MASK_W-1:0] dst_mask_i,
   input  logic [MASK_W-1:0] cr_eq_i,
   input  logic              src_inv_i,
   input  logic              dst_inv_i,
   input  logic              single_i,
   input  logic              cr_sel_i,
   input  logic              zero_i,
   input  logic              src_scalar_i,
   input  logic              dst_scalar_i,
   output logic              issue_o,
   output logic [IDX_W-1:0]  src_idx_o,
   output logic [IDX_W-1:0]  dst_idx_o,
   output logic              wr_zero_o,
   output logic [VL_W-1:0]   src_step_o,
   output logic [VL_W-1:0]   dst_step_o,
   output logic              done_o
);

   if (MASK_W < 2) begin : g_bad_mask
      $error("pred_elem_seq: MASK_W must be at least 2");
   end
   if (VL_W < $clog2(MASK_W + 1)) begin : g_bad_vl
      $error("pred_elem_seq: VL_W too narrow to hold MASK_W");
   end

   logic [MASK_W-1:0] s_eff;
   logic [MASK_W-1:0] d_eff;
   logic [MASK_W-1:0] smask_q;
   logic [MASK_W-1:0] dmask_q;
   logic              s_found;
   logic              d_found;
   logic [IDX_W-1:0]  s_idx;
   logic [IDX_W-1:0]  d_idx;

   tps_mask_prep #(.MASK_W(MASK_W), .VL_W(VL_W)) u_prep (
      .vl_i       (vl_i),
      .src_mask_i (src_mask_i),
      .dst_mask_i (dst_mask_i),
      .cr_eq_i    (cr_eq_i),
      .src_inv_i  (src_inv_i),
      .dst_inv_i  (dst_inv_i),
      .single_i   (single_i),
      .cr_sel_i   (cr_sel_i),
      .s_eff_o    (s_eff),
      .d_eff_o    (d_eff)
   );

   tps_next_set #(.MASK_W(MASK_W), .VL_W(VL_W), .IMPL(FIND_IMPL)) u_find_src (
      .mask_i  (smask_q),
      .from_i  (src_step_o),
      .found_o (s_found),
      .idx_o   (s_idx)
   );

   tps_next_set #(.MASK_W(MASK_W), .VL_W(VL_W), .IMPL(FIND_IMPL)) u_find_dst (
      .mask_i  (dmask_q),
      .from_i  (dst_step_o),
      .found_o (d_found),
      .idx_o   (d_idx)
   );

   tps_step_ctrl #(.MASK_W(MASK_W), .VL_W(VL_W)) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .vl_i         (vl_i),
      .src_step_i   (src_step_i),
      .dst_step_i   (dst_step_i),
      .s_eff_i      (s_eff),
      .d_eff_i      (d_eff),
      .zero_i       (zero_i),
      .src_scalar_i (src_scalar_i),
      .dst_scalar_i (dst_scalar_i),
      .s_found_i    (s_found),
      .s_idx_i      (s_idx),
      .d_found_i    (d_found),
      .d_idx_i      (d_idx),
      .smask_o      (smask_q),
      .dmask_o      (dmask_q),
      .src_step_o   (src_step_o),
      .dst_step_o   (dst_step_o),
      .issue_o      (issue_o),
      .src_idx_o    (src_idx_o),
      .dst_idx_o    (dst_idx_o),
      .wr_zero_o    (wr_zero_o),
      .done_o       (done_o)
   );

endmodule

// File: rtl/pred_elem_seq_chk.sv
module pred_elem_seq_chk #(
   parameter int VL_W  = 7,
   parameter int IDX_W = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             issue_o,
   input logic             done_o,
   input logic [IDX_W-1:0] dst_idx_o,
   input logic             wr_zero_o,
   input logic [VL_W-1:0]  src_step_o,
   input logic [VL_W-1:0]  dst_step_o
);

   // R12
   done_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !issue_o);

   // R12
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R12
   done_steps_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (src_step_o == '0 && dst_step_o == '0));

   // R11
   step_follows_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
      issue_o |-> (dst_step_o == VL_W'(dst_idx_o) + VL_W'(1)));

   // R3
   dst_rising_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_o && $past(issue_o)) |-> (dst_idx_o > $past(dst_idx_o)));

   // R6
   zero_needs_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_zero_o |-> issue_o);

endmodule

bind pred_elem_seq pred_elem_seq_chk #(.VL_W(VL_W), .IDX_W(IDX_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .issue_o    (issue_o),
   .done_o     (done_o),
   .dst_idx_o  (dst_idx_o),
   .wr_zero_o  (wr_zero_o),
   .src_step_o (src_step_o),
   .dst_step_o (dst_step_o)
);

// File: tb/pred_elem_seq_tb.sv
`timescale 1ns/1ps
module pred_elem_seq_tb;

   localparam int MASK_W = 64;
   localparam int VL_W   = 7;
   localparam int IDX_W  = 6;
   localparam int NCASE  = 14;

   // fl: {src_inv, dst_inv, zero, dst_scalar, src_scalar, single, cr_sel}
   // exp: pair k in byte k = {zero, src[2:0], 1'b0, dst[2:0]}
   typedef struct packed {
      logic [6:0]  vl;
      logic [6:0]  ss;
      logic [6:0]  ds;
      logic [15:0] sm;
      logic [15:0] dm;
      logic [15:0] cr;
      logic [6:0]  fl;
      logic [2:0]  cnt;
      logic [31:0] exp;
   } vec_t;

   localparam vec_t TBL [NCASE] = '{
      '{7'd2, 7'd0, 7'd0, 16'h2, 16'h2, 16'h0, 7'b1000000, 3'd1, 32'h01},   // R4 R3 remap
      '{7'd2, 7'd0, 7'd0, 16'h3, 16'h1, 16'h0, 7'b0010000, 3'd2, 32'h9100}, // R6
      '{7'd3, 7'd0, 7'd0, 16'h5, 16'h7, 16'h0, 7'b0000000, 3'd2, 32'h2100}, // R2 compress
      '{7'd3, 7'd0, 7'd0, 16'h7, 16'h5, 16'h0, 7'b0000000, 3'd2, 32'h1200}, // R3 expand
      '{7'd3, 7'd0, 7'd0, 16'h5, 16'h5, 16'h0, 7'b0100000, 3'd1, 32'h01},   // R4 twin
      '{7'd4, 7'd1, 7'd2, 16'h5, 16'h5, 16'h0, 7'b0100000, 3'd1, 32'h23},   // R8 resume
      '{7'd0, 7'd0, 7'd0, 16'hF, 16'hF, 16'h0, 7'b0000000, 3'd0, 32'h0},    // R7
      '{7'd3, 7'd0, 7'd0, 16'h7, 16'h7, 16'h0, 7'b0001000, 3'd1, 32'h00},   // R9 dst scalar
      '{7'd2, 7'd0, 7'd0, 16'h4, 16'h7, 16'h0, 7'b0000000, 3'd0, 32'h0},    // R5 bit above vl
      '{7'd2, 7'd0, 7'd0, 16'h1, 16'h3, 16'h0, 7'b1000000, 3'd1, 32'h10},   // R4 R5
      '{7'd3, 7'd0, 7'd0, 16'h3, 16'h0, 16'h0, 7'b0010000, 3'd2, 32'h9180}, // R6 all zero
      '{7'd2, 7'd0, 7'd0, 16'hFFFF, 16'h0, 16'h1, 7'b1000011, 3'd1, 32'h11},// R10 cr bits
      '{7'd4, 7'd0, 7'd0, 16'h6, 16'h0, 16'h0, 7'b0000010, 3'd2, 32'h2211}, // R10 shared int
      '{7'd2, 7'd0, 7'd0, 16'h3, 16'h3, 16'h0, 7'b0000100, 3'd2, 32'h0100}  // R9 src scalar
   };

   logic              clk = 1'b0;
   logic              rst_n;
   logic              start_i;
   logic [VL_W-1:0]   vl_i, src_step_i, dst_step_i;
   logic [MASK_W-1:0] src_mask_i, dst_mask_i, cr_eq_i;
   logic              src_inv_i, dst_inv_i, single_i, cr_sel_i;
   logic              zero_i, src_scalar_i, dst_scalar_i;
   logic              issue_o, wr_zero_o, done_o;
   logic [IDX_W-1:0]  src_idx_o, dst_idx_o;
   logic [VL_W-1:0]   src_step_o, dst_step_o;

   int n_cmp = 0;
   int n_bad = 0;
   int cyc   = 0;

   always #2 clk = ~clk;

   pred_elem_seq u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .vl_i(vl_i),
      .src_step_i(src_step_i), .dst_step_i(dst_step_i),
      .src_mask_i(src_mask_i), .dst_mask_i(dst_mask_i), .cr_eq_i(cr_eq_i),
      .src_inv_i(src_inv_i), .dst_inv_i(dst_inv_i), .single_i(single_i),
      .cr_sel_i(cr_sel_i), .zero_i(zero_i), .src_scalar_i(src_scalar_i),
      .dst_scalar_i(dst_scalar_i), .issue_o(issue_o), .src_idx_o(src_idx_o),
      .dst_idx_o(dst_idx_o), .wr_zero_o(wr_zero_o), .src_step_o(src_step_o),
      .dst_step_o(dst_step_o), .done_o(done_o)
   );

   task automatic chk(input bit ok, input string what, input longint act, input longint exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         n_cmp++;
         n_bad++;
         $display("FAIL R11 watchdog actual=%0d expected=<20000", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   task automatic scramble();
      vl_i = 7'd9; src_step_i = '0; dst_step_i = '0;
      src_mask_i = '1; dst_mask_i = '1; cr_eq_i = '1;
      src_inv_i = 1'b1; dst_inv_i = 1'b1; single_i = 1'b1; cr_sel_i = 1'b1;
      zero_i = 1'b1; src_scalar_i = 1'b1; dst_scalar_i = 1'b1;
   endtask

   // Called at a negedge; returns at the negedge in which done_o is seen.
   task automatic run_case(input vec_t v, input int id);
      int k = 0;
      vl_i = v.vl; src_step_i = v.ss; dst_step_i = v.ds;
      src_mask_i = MASK_W'(v.sm); dst_mask_i = MASK_W'(v.dm); cr_eq_i = MASK_W'(v.cr);
      {src_inv_i, dst_inv_i, zero_i, dst_scalar_i, src_scalar_i, single_i, cr_sel_i} = v.fl;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      scramble();
      chk(src_step_o == v.ss && dst_step_o == v.ds && !issue_o,
          $sformatf("R8 case %0d steps loaded", id),
          {src_step_o, dst_step_o}, {v.ss, v.ds});
      for (int g = 0; g < 300; g++) begin
         @(negedge clk);
         start_i = 1'b0;
         if (issue_o) begin
            if (k < int'(v.cnt)) begin
               logic [7:0] e;
               e = v.exp[8*k +: 8];
               chk(src_idx_o == IDX_W'(e[6:4]) && dst_idx_o == IDX_W'(e[2:0]) && wr_zero_o == e[7],
                   $sformatf("R2/R3 case %0d pair %0d", id, k),
                   {wr_zero_o, src_idx_o, dst_idx_o}, {e[7], IDX_W'(e[6:4]), IDX_W'(e[2:0])});
            end else begin
               chk(1'b0, $sformatf("R5 case %0d surplus pair", id), k, v.cnt);
            end
            chk(dst_step_o == VL_W'(dst_idx_o) + VL_W'(1),
                $sformatf("R11 case %0d step tracks pair", id), dst_step_o, dst_idx_o + 1);
            k++;
            // R12: start while running must be ignored
            if (k == 1 && v.cnt >= 2) start_i = 1'b1;
         end
         if (done_o) break;
      end
      chk(done_o == 1'b1, $sformatf("R12 case %0d done seen", id), done_o, 1);
      chk(k == int'(v.cnt), $sformatf("R5 case %0d pair count", id), k, v.cnt);
      chk(src_step_o == '0 && dst_step_o == '0 && !issue_o,
          $sformatf("R12 case %0d steps cleared at done", id),
          {issue_o, src_step_o, dst_step_o}, 0);
   endtask

   initial begin
      rst_n = 1'b0;
      start_i = 1'b0;
      scramble();
      repeat (3) @(negedge clk);
      chk(!issue_o && !done_o && !wr_zero_o && src_idx_o == '0 && dst_idx_o == '0
          && src_step_o == '0 && dst_step_o == '0, "R1 reset state",
          {issue_o, done_o, wr_zero_o, src_idx_o, dst_idx_o, src_step_o, dst_step_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // Table walk; each case starts in the done cycle of the previous one (R12).
      for (int i = 0; i < NCASE; i++) run_case(TBL[i], i);

      // R5 R11: widest indices, element 63 into element 0
      vl_i = 7'd64; src_step_i = '0; dst_step_i = '0;
      src_mask_i = 64'h1 << 63; dst_mask_i = 64'h1; cr_eq_i = '0;
      {src_inv_i, dst_inv_i, zero_i, dst_scalar_i, src_scalar_i, single_i, cr_sel_i} = '0;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      @(negedge clk);
      chk(issue_o && src_idx_o == 6'd63 && dst_idx_o == 6'd0, "R5 top element pair",
          {issue_o, src_idx_o, dst_idx_o}, {1'b1, 6'd63, 6'd0});
      chk(src_step_o == 7'd64 && dst_step_o == 7'd1, "R11 top element steps",
          {src_step_o, dst_step_o}, {7'd64, 7'd1});
      @(negedge clk);
      chk(done_o && !issue_o, "R5 loop ends at vector length", {done_o, issue_o}, 2'b10);
      @(negedge clk);
      chk(!done_o && !issue_o && src_step_o == '0 && dst_step_o == '0,
          "R12 done is a single pulse", {done_o, issue_o, src_step_o, dst_step_o}, 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule